// File: doc/BRIEF.md
# Transmit Timestamp Holding Register

This block sits next to the transmit side of an Ethernet MAC and records the time-of-day at the moment a frame that asked for a timestamp starts on the wire. A start-of-frame strobe, qualified by a per-frame "timestamp wanted" flag, latches the free-running seconds and nanoseconds counters into a single holding slot. It sets a valid flag that software polls.

Software reads the nanoseconds and seconds words and forms the full time as seconds times 1e9 plus nanoseconds. It then gives the slot back by writing the clear register twice: first with the finish code, then with the update code. Until that hand-back completes, the slot is locked. Later requests do not overwrite it; each one that arrives in that state adds one to a saturating missed-capture counter. If a timestamp never turns valid, software gives up on it after its own timeout, so the block itself keeps no timer.

Top module: `tx_stamp_hold`

## Requirements
- R1: After reset, the valid flag (bit 0 of `stampStatus`, all other status bits zero), `stampNs`, `stampSec` and `missCount` are all zero.
- R2: A cycle with `sofStrobe` and `stampWanted` both high while the slot is empty sets the valid flag on the following clock edge. A strobe without `stampWanted` has no effect.
- R3: On capture, `stampNs` holds the low `NS_FIELD_W` bits (default 30) of `timeNs`, zero-extended with the upper bits cleared. `stampSec` holds the low `SEC_FIELD_W` bits (default 32) of `timeSec`.
- R4: Seconds and nanoseconds are both taken from the same clock edge, the one at which the qualified strobe is sampled.
- R5: While the valid flag is set, a qualified strobe leaves `stampNs`, `stampSec` and the valid flag unchanged.
- R6: Each qualified strobe sampled while the valid flag is set increments `missCount` by one on that edge.
- R7: The valid flag clears only when a write of the update code (`clrData` = 2'b00) immediately follows a write of the finish code (`clrData` = 2'b01) in the sequence of writes (`clrWrite` high). A lone finish write, a lone update write, or a finish, any other code, then update sequence leaves the flag set.
- R8: `missCount` saturates at its all-ones value.
- R9: After a release, the next qualified strobe captures the new time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofStrobe | input | 1 | Start-of-frame pulse from the transmit path |
| stampWanted | input | 1 | Frame asks for a timestamp; qualifies `sofStrobe` |
| timeSec | input | REG_W | Time counter, seconds |
| timeNs | input | REG_W | Time counter, nanoseconds |
| clrWrite | input | 1 | Write strobe for the clear register |
| clrData | input | CLR_W | Code written to the clear register |
| stampStatus | output | REG_W | Status word; bit 0 is the valid flag |
| stampNs | output | REG_W | Held nanoseconds, masked to field |
| stampSec | output | REG_W | Held seconds, masked to field |
| missCount | output | MISS_W | Saturating count of requests dropped while the slot was full |

## Verification
The hardest case to reach is the saturation of the missed-capture counter. It needs the slot held full across more qualified strobes than the counter can represent. The bench captures once, then keeps sending strobes without ever writing the clear register, and runs past the wrap point. A second awkward case is a broken hand-back: the bench writes finish, then a foreign code, then update, and checks that the slot stays locked.

// File: rtl/tx_stamp_pkg.sv
package tx_stamp_pkg;
  typedef struct packed {
    logic capture;
    logic miss;
    logic freeHold;
  } stamp_ctl_t;

  localparam logic [1:0] CLR_FINISH = 2'b01;
  localparam logic [1:0] CLR_UPDATE = 2'b00;
endpackage

// File: rtl/tx_stamp_ctl.sv
module tx_stamp_ctl
  import tx_stamp_pkg::*;
#(
  parameter int CLR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sofStrobe,
  input  logic             stampWanted,
  input  logic             clrWrite,
  input  logic [CLR_W-1:0] clrData,
  output stamp_ctl_t       ctl,
  output logic             validQ
);
  logic armedQ;
  logic hit;
  logic isFinish;
  logic isUpdate;

  assign hit      = sofStrobe && stampWanted;
  assign isFinish = (clrData == CLR_W'(CLR_FINISH));
  assign isUpdate = (clrData == CLR_W'(CLR_UPDATE));

  always_comb begin
    ctl.capture  = hit && !validQ;
    ctl.miss     = hit && validQ;
    ctl.freeHold = clrWrite && isUpdate && armedQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      if (ctl.capture)       validQ <= 1'b1;
      else if (ctl.freeHold) validQ <= 1'b0;

      if (ctl.capture)  armedQ <= 1'b0;
      else if (clrWrite) armedQ <= isFinish;
    end
  end

  // R2: valid only rises after a qualified strobe
  a_r2_rise_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> $past(sofStrobe && stampWanted));

  // R7: valid only falls after an update write that followed a finish
  a_r7_release_seq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(validQ) |-> $past(clrWrite && isUpdate && armedQ));
endmodule

// File: rtl/tx_stamp_dp.sv
module tx_stamp_dp
  import tx_stamp_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int NS_FIELD_W  = 30,
  parameter int SEC_FIELD_W = 32,
  parameter int MISS_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stamp_ctl_t        ctl,
  input  logic              validIn,
  input  logic [REG_W-1:0]  timeSec,
  input  logic [REG_W-1:0]  timeNs,
  output logic [REG_W-1:0]  nsQ,
  output logic [REG_W-1:0]  secQ,
  output logic [MISS_W-1:0] missQ
);
  localparam logic [REG_W-1:0]  NS_MASK  = REG_W'((64'd1 << NS_FIELD_W) - 64'd1);
  localparam logic [REG_W-1:0]  SEC_MASK = REG_W'((64'd1 << SEC_FIELD_W) - 64'd1);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nsQ   <= '0;
      secQ  <= '0;
      missQ <= '0;
    end else begin
      if (ctl.capture) begin
        nsQ  <= timeNs & NS_MASK;
        secQ <= timeSec & SEC_MASK;
      end
      if (ctl.miss && missQ != MISS_MAX) missQ <= missQ + 1'b1;
    end
  end

  // R5: a held pair never changes while the slot is full
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    $past(validIn) |-> ($stable(nsQ) && $stable(secQ)));

  // R6: the miss counter only moves while the slot is full
  a_r6_miss_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (missQ != $past(missQ)) |-> $past(validIn));

  // R8: once at the top, the counter stays there
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    ($past(missQ) == MISS_MAX) |-> (missQ == MISS_MAX));
endmodule

// File: rtl/tx_stamp_hold.sv
module tx_stamp_hold
  import tx_stamp_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int NS_FIELD_W  = 30,
  parameter int SEC_FIELD_W = 32,
  parameter int MISS_W      = 8,
  parameter int CLR_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofStrobe,
  input  logic              stampWanted,
  input  logic [REG_W-1:0]  timeSec,
  input  logic [REG_W-1:0]  timeNs,
  input  logic              clrWrite,
  input  logic [CLR_W-1:0]  clrData,
  output logic [REG_W-1:0]  stampStatus,
  output logic [REG_W-1:0]  stampNs,
  output logic [REG_W-1:0]  stampSec,
  output logic [MISS_W-1:0] missCount
);
  stamp_ctl_t ctl;
  logic       validQ;

  tx_stamp_ctl #(.CLR_W(CLR_W)) uCtl (
    .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .stampWanted(stampWanted),
    .clrWrite(clrWrite), .clrData(clrData), .ctl(ctl), .validQ(validQ)
  );

  tx_stamp_dp #(
    .REG_W(REG_W), .NS_FIELD_W(NS_FIELD_W),
    .SEC_FIELD_W(SEC_FIELD_W), .MISS_W(MISS_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .validIn(validQ),
    .timeSec(timeSec), .timeNs(timeNs),
    .nsQ(stampNs), .secQ(stampSec), .missQ(missCount)
  );

  assign stampStatus = {{(REG_W-1){1'b0}}, validQ};
endmodule

// File: tb/tx_stamp_hold_test.sv
module tx_stamp_hold_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sofStrobe = 1'b0;
  logic        stampWanted = 1'b0;
  logic [31:0] timeSec = '0;
  logic [31:0] timeNs = '0;
  logic        clrWrite = 1'b0;
  logic [1:0]  clrData = '0;
  logic [31:0] stampStatus, stampNs, stampSec;
  logic [7:0]  missCount;

  int testsRun = 0;
  int testsFailed = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  tx_stamp_hold uut (
    .clk(clk), .rstN(rstN), .sofStrobe(sofStrobe), .stampWanted(stampWanted),
    .timeSec(timeSec), .timeNs(timeNs), .clrWrite(clrWrite), .clrData(clrData),
    .stampStatus(stampStatus), .stampNs(stampNs), .stampSec(stampSec),
    .missCount(missCount)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  // one qualified or unqualified strobe; outputs valid at the following negedge
  task automatic strobe(input logic want, input logic [31:0] s, input logic [31:0] n);
    @(negedge clk);
    sofStrobe = 1'b1; stampWanted = want; timeSec = s; timeNs = n;
    @(negedge clk);
    sofStrobe = 1'b0; stampWanted = 1'b0;
  endtask

  task automatic clrWr(input logic [1:0] code);
    @(negedge clk); clrWrite = 1'b1; clrData = code;
    @(negedge clk); clrWrite = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 status", stampStatus, 0);
    chk("R1 ns", stampNs, 0);
    chk("R1 sec", stampSec, 0);
    chk("R1 miss", missCount, 0);
  endtask

  task automatic testUnqualified();
    doReset();
    strobe(1'b0, 32'h11, 32'h22);
    chk("R2 no request ignored valid", stampStatus, 0);
    chk("R2 no request ignored ns", stampNs, 0);
  endtask

  task automatic testCaptureMask();
    doReset();
    strobe(1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    chk("R2 valid set", stampStatus, 1);
    chk("R3 ns masked", stampNs, 32'h3FFF_FFFF);
    chk("R3 sec", stampSec, 32'hDEAD_BEEF);
  endtask

  task automatic testCoherent();
    doReset();
    // time values change every cycle; strobe lands in the middle
    @(negedge clk); timeSec = 32'd100; timeNs = 32'd500;
    @(negedge clk); timeSec = 32'd101; timeNs = 32'd600;
    sofStrobe = 1'b1; stampWanted = 1'b1;
    @(negedge clk); timeSec = 32'd102; timeNs = 32'd700;
    sofStrobe = 1'b0; stampWanted = 1'b0;
    chk("R4 coherent sec", stampSec, 101);
    chk("R4 coherent ns", stampNs, 600);
  endtask

  task automatic testBlockAndMiss();
    doReset();
    strobe(1'b1, 32'd5, 32'd50);
    strobe(1'b1, 32'd6, 32'd60);
    strobe(1'b1, 32'd7, 32'd70);
    chk("R5 sec held", stampSec, 5);
    chk("R5 ns held", stampNs, 50);
    chk("R5 valid held", stampStatus, 1);
    chk("R6 miss two", missCount, 2);
    strobe(1'b0, 32'd8, 32'd80);
    chk("R6 unqualified no miss", missCount, 2);
  endtask

  task automatic testHandshake();
    doReset();
    strobe(1'b1, 32'd9, 32'd90);
    clrWr(2'b00);
    chk("R7 lone update keeps valid", stampStatus, 1);
    clrWr(2'b01);
    chk("R7 lone finish keeps valid", stampStatus, 1);
    clrWr(2'b10);
    clrWr(2'b00);
    chk("R7 broken sequence keeps valid", stampStatus, 1);
    clrWr(2'b01);
    clrWr(2'b00);
    chk("R7 finish then update clears", stampStatus, 0);
    strobe(1'b1, 32'd12, 32'd120);
    chk("R9 recapture valid", stampStatus, 1);
    chk("R9 recapture sec", stampSec, 12);
    chk("R9 recapture ns", stampNs, 120);
  endtask

  task automatic testSaturate();
    doReset();
    strobe(1'b1, 32'd1, 32'd1);
    @(negedge clk); sofStrobe = 1'b1; stampWanted = 1'b1;
    for (int i = 0; i < 254; i++) @(negedge clk);
    sofStrobe = 1'b0; stampWanted = 1'b0;
    chk("R6 count 254", missCount, 254);
    strobe(1'b1, 32'd2, 32'd2);
    chk("R8 reach max", missCount, 255);
    strobe(1'b1, 32'd3, 32'd3);
    strobe(1'b1, 32'd4, 32'd4);
    chk("R8 saturated", missCount, 255);
    chk("R5 still first stamp", stampSec, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testReset();
    testUnqualified();
    testCaptureMask();
    testCoherent();
    testBlockAndMiss();
    testHandshake();
    testSaturate();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule